// File: doc/BRIEF.md
# Queued SPI Interrupt and Error Control

This block holds the interrupt and error control register of a queued SPI controller and keeps its three status flags current. The flags are queue finished, abort and write collision. A collision is a CPU write that lands on the command entry the engine is executing. An abort is a software attempt to clear the SPI enable bit while a transfer runs. The finished flag marks the end of a queue pass, or a stop that software asked for with halt.

Each flag feeds the interrupt request through its own enable. The collision and abort events can also be turned into a bus access error. The offending write is then blocked: the RAM entry keeps its value, or the enable bit stays set. A lock-out option removes software's ability to clear the enable bit at all. The shift engine sits outside this block. It supplies the command-complete pulse, the current and end queue pointers, the halt request and the wraparound mode.

Top module: `qspi_irq_ctl`

## Requirements
- R1: The 16-bit register reads back six enables and three flags, each at a fixed bit position:
  - bit 15: collision error enable
  - bit 14: abort error enable
  - bit 12: lock-out
  - bit 11: collision interrupt enable
  - bit 10: abort interrupt enable
  - bit 8: finished interrupt enable
  - bit 3: collision flag
  - bit 2: abort flag
  - bit 0: finished flag

  Bits 13, 9, 7 to 4 and 1 always read 0. A register write loads all six enables from the written data.
- R2: The collision flag (bit 3) sets on the clock edge after a cycle in which four conditions all hold: `xfer_active` is high, `ram_wr_req` is high, `ram_wr_cmd` is high, and `ram_wr_idx` equals `cur_ptr`. A write to any other index, or any write outside a transfer, leaves the flag unchanged.
- R3: When a collision occurs with bit 15 set, `access_err` is high in that same cycle and `ram_wr_ok` is low. With bit 15 clear, `ram_wr_ok` follows `ram_wr_req` and no access error is raised.
- R4: With lock-out (bit 12) clear, `spe_clr_req` during a transfer sets the abort flag (bit 2) on the next edge. Outside a transfer it never sets the flag.
- R5: When an abort occurs with bit 14 set, `access_err` is high in that cycle and `spe_clr_ok` is low. The abort flag still sets. With bit 14 clear, `spe_clr_ok` follows `spe_clr_req`.
- R6: While lock-out (bit 12) is set, `spe_clr_ok` stays low. A clear request then sets no abort flag and raises no access error.
- R7: A `cmd_done` pulse with `cur_ptr` equal to `end_ptr` sets the finished flag (bit 0) on the next edge, provided the queue is armed. A `cmd_done` at any other pointer does not set it.
- R8: A `cmd_done` pulse while `halt_req` is high sets the finished flag, whatever the pointers, provided the queue is armed. A halt-caused finish always disarms the queue.
- R9: A rising edge of `xfer_active` arms the queue. With `wrap_en` low, a finish disarms it, so further end completions set no flag until the next rising edge. With `wrap_en` high, every end completion sets the flag again.
- R10: Writing 1 to bit 3, 2 or 0 clears that flag. Writing 0 to a flag leaves it unchanged.
- R11: If a flag's set event and a write-1 clear of that flag fall in the same cycle, the flag ends up set.
- R12: `irq` is high exactly while at least one flag is set together with its enable: bit 3 with bit 11, bit 2 with bit 10, or bit 0 with bit 8. It holds at level until a register write removes the condition.
- R13: After reset, the register reads 0, `irq` and `access_err` are low, and the queue is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read value |
| xfer_active | input | 1 | Transfer in progress |
| spe_clr_req | input | 1 | Software attempts to clear the SPI enable bit |
| spe_clr_ok | output | 1 | Clear of the SPI enable bit is permitted |
| ram_wr_req | input | 1 | CPU write to queue RAM through the data port |
| ram_wr_cmd | input | 1 | The RAM write targets the command section |
| ram_wr_idx | input | PTR_W | Entry index of the RAM write |
| ram_wr_ok | output | 1 | RAM write is permitted |
| cmd_done | input | 1 | Engine finished a command (one-cycle pulse) |
| cur_ptr | input | PTR_W | Command entry being executed |
| end_ptr | input | PTR_W | Last entry of the queue |
| halt_req | input | 1 | Halt requested |
| wrap_en | input | 1 | Wraparound mode |
| irq | output | 1 | Interrupt request, level |
| access_err | output | 1 | Bus access error for the current write |

## Verification
The hardest situation to reach is a hardware flag set and a software write-1 clear of the same flag in a single cycle. Close behind it is the second end-queue completion in a pass, which must set the flag again in wraparound mode but not in single-pass mode. Directed sequences arm the queue by raising `xfer_active`, clear the flag, and then pulse `cmd_done` at the end pointer. In the collision test, the same cycle also carries a register write of 1. The random phase keeps the pointers in a four-entry range, so pointer matches, halts and RAM index hits occur often. It also toggles the transfer and wrap inputs, so single-pass and wraparound re-arming alternate many times.

// File: rtl/qspi_irq_pkg.sv
package qspi_irq_pkg;

  localparam int REG_W     = 16;
  localparam int NFLAG     = 3;

  // Bit positions inside the control register.
  localparam int B_COLL_ERR = 15;
  localparam int B_ABRT_ERR = 14;
  localparam int B_LOCK     = 12;
  localparam int B_COLL_IE  = 11;
  localparam int B_ABRT_IE  = 10;
  localparam int B_FIN_IE   = 8;
  localparam int B_COLL_F   = 3;
  localparam int B_ABRT_F   = 2;
  localparam int B_FIN_F    = 0;

  // Flag vector index.
  typedef enum int {
    FLG_FIN  = 0,
    FLG_ABRT = 1,
    FLG_COLL = 2
  } flag_idx_e;

  typedef struct packed {
    logic coll_err;
    logic abrt_err;
    logic lock;
    logic coll_ie;
    logic abrt_ie;
    logic fin_ie;
  } cfg_t;

  function automatic cfg_t cfg_from_word(input logic [REG_W-1:0] w);
    cfg_t c;
    c.coll_err = w[B_COLL_ERR];
    c.abrt_err = w[B_ABRT_ERR];
    c.lock     = w[B_LOCK];
    c.coll_ie  = w[B_COLL_IE];
    c.abrt_ie  = w[B_ABRT_IE];
    c.fin_ie   = w[B_FIN_IE];
    return c;
  endfunction

  // Write-1-to-clear mask, indexed like the flag vector.
  function automatic logic [NFLAG-1:0] clr_from_word(input logic [REG_W-1:0] w);
    logic [NFLAG-1:0] m;
    m[FLG_FIN]  = w[B_FIN_F];
    m[FLG_ABRT] = w[B_ABRT_F];
    m[FLG_COLL] = w[B_COLL_F];
    return m;
  endfunction

  function automatic logic [REG_W-1:0] word_from_state(input cfg_t c,
                                                       input logic [NFLAG-1:0] f);
    logic [REG_W-1:0] w;
    w = '0;
    w[B_COLL_ERR] = c.coll_err;
    w[B_ABRT_ERR] = c.abrt_err;
    w[B_LOCK]     = c.lock;
    w[B_COLL_IE]  = c.coll_ie;
    w[B_ABRT_IE]  = c.abrt_ie;
    w[B_FIN_IE]   = c.fin_ie;
    w[B_COLL_F]   = f[FLG_COLL];
    w[B_ABRT_F]   = f[FLG_ABRT];
    w[B_FIN_F]    = f[FLG_FIN];
    return w;
  endfunction

  // Set has priority over a same-cycle clear.
  function automatic logic w1c_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic [NFLAG-1:0] ie_vec(input cfg_t c);
    logic [NFLAG-1:0] v;
    v[FLG_FIN]  = c.fin_ie;
    v[FLG_ABRT] = c.abrt_ie;
    v[FLG_COLL] = c.coll_ie;
    return v;
  endfunction

endpackage

// File: rtl/qspi_irq_evt.sv
module qspi_irq_evt #(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_active,
  input  logic             ram_wr_req,
  input  logic             ram_wr_cmd,
  input  logic [PTR_W-1:0] ram_wr_idx,
  input  logic             spe_clr_req,
  input  logic             abrt_lock,
  input  logic             cmd_done,
  input  logic [PTR_W-1:0] cur_ptr,
  input  logic [PTR_W-1:0] end_ptr,
  input  logic             halt_req,
  input  logic             wrap_en,
  output logic             evt_coll,
  output logic             evt_abort,
  output logic             evt_fin
);

  logic xfer_q;
  logic armed_q;
  logic armed_d;
  logic xfer_start;
  logic end_hit;
  logic disarm;

  assign xfer_start = xfer_active & ~xfer_q;
  assign end_hit    = (cur_ptr == end_ptr) | halt_req;

  assign evt_coll  = xfer_active & ram_wr_req & ram_wr_cmd & (ram_wr_idx == cur_ptr);
  assign evt_abort = xfer_active & spe_clr_req & ~abrt_lock;
  assign evt_fin   = cmd_done & end_hit & (armed_q | xfer_start);

  assign disarm = evt_fin & (~wrap_en | halt_req);

  always_comb begin
    armed_d = armed_q;
    if (xfer_start) armed_d = 1'b1;
    if (disarm)     armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      xfer_q  <= xfer_active;
      armed_q <= armed_d;
    end
  end

endmodule

// File: rtl/qspi_irq_flags.sv
module qspi_irq_flags
  import qspi_irq_pkg::*;
#(
  parameter int N = NFLAG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_q
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= w1c_next(flag_q[i], set_i[i], clr_i[i]);
    end
  end

endmodule

// File: rtl/qspi_irq_cfg.sv
module qspi_irq_cfg
  import qspi_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output cfg_t             cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (reg_wr) cfg_q <= cfg_from_word(reg_wdata);
  end

endmodule

// File: rtl/qspi_irq_ctl.sv
module qspi_irq_ctl
  import qspi_irq_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  input  logic             xfer_active,
  input  logic             spe_clr_req,
  output logic             spe_clr_ok,
  input  logic             ram_wr_req,
  input  logic             ram_wr_cmd,
  input  logic [PTR_W-1:0] ram_wr_idx,
  output logic             ram_wr_ok,
  input  logic             cmd_done,
  input  logic [PTR_W-1:0] cur_ptr,
  input  logic [PTR_W-1:0] end_ptr,
  input  logic             halt_req,
  input  logic             wrap_en,
  output logic             irq,
  output logic             access_err
);

  cfg_t             cfg_q;
  logic [NFLAG-1:0] flag_q;
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_clr;

  // Named internal events, brought out for the checker.
  logic evt_coll;
  logic evt_abort;
  logic evt_fin;
  logic coll_err;
  logic abrt_err;

  qspi_irq_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .cfg_q     (cfg_q)
  );

  qspi_irq_evt #(.PTR_W(PTR_W)) u_evt (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_active (xfer_active),
    .ram_wr_req  (ram_wr_req),
    .ram_wr_cmd  (ram_wr_cmd),
    .ram_wr_idx  (ram_wr_idx),
    .spe_clr_req (spe_clr_req),
    .abrt_lock   (cfg_q.lock),
    .cmd_done    (cmd_done),
    .cur_ptr     (cur_ptr),
    .end_ptr     (end_ptr),
    .halt_req    (halt_req),
    .wrap_en     (wrap_en),
    .evt_coll    (evt_coll),
    .evt_abort   (evt_abort),
    .evt_fin     (evt_fin)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FLG_FIN]  = evt_fin;
    flag_set[FLG_ABRT] = evt_abort;
    flag_set[FLG_COLL] = evt_coll;
  end

  assign flag_clr = reg_wr ? clr_from_word(reg_wdata) : '0;

  qspi_irq_flags #(.N(NFLAG)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flag_q (flag_q)
  );

  assign coll_err   = evt_coll & cfg_q.coll_err;
  assign abrt_err   = evt_abort & cfg_q.abrt_err;
  assign access_err = coll_err | abrt_err;
  assign ram_wr_ok  = ram_wr_req & ~coll_err;
  assign spe_clr_ok = spe_clr_req & ~cfg_q.lock & ~abrt_err;

  assign irq       = |(flag_q & ie_vec(cfg_q));
  assign reg_rdata = word_from_state(cfg_q, flag_q);

endmodule

// File: rtl/qspi_irq_chk.sv
module qspi_irq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        ram_wr_req,
  input logic        spe_clr_req,
  input logic [15:0] reg_rdata,
  input logic        irq,
  input logic        access_err,
  input logic        spe_clr_ok,
  input logic        ram_wr_ok,
  input logic        evt_coll,
  input logic        evt_abort,
  input logic        evt_fin
);

  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & 16'h22F2) == 16'h0000);

  assert_coll_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_coll |=> reg_rdata[3]);

  assert_coll_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (access_err && !spe_clr_req) |-> !ram_wr_ok);

  assert_abort_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_abort |=> reg_rdata[2]);

  assert_abort_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (access_err && !ram_wr_req) |-> !spe_clr_ok);

  assert_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[12] |-> !spe_clr_ok);

  assert_fin_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fin |=> reg_rdata[0]);

  assert_w1c_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata[0]) |-> $past(reg_wr));

  assert_irq_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(reg_wr));

endmodule

bind qspi_irq_ctl qspi_irq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .ram_wr_req  (ram_wr_req),
  .spe_clr_req (spe_clr_req),
  .reg_rdata   (reg_rdata),
  .irq         (irq),
  .access_err  (access_err),
  .spe_clr_ok  (spe_clr_ok),
  .ram_wr_ok   (ram_wr_ok),
  .evt_coll    (evt_coll),
  .evt_abort   (evt_abort),
  .evt_fin     (evt_fin)
);

// File: tb/test_qspi_irq_ctl.sv
`timescale 1ns/1ps
module test_qspi_irq_ctl;

  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 0;
  logic [15:0]   reg_wdata = 0;
  logic [15:0]   reg_rdata;
  logic          xfer_active = 0, spe_clr_req = 0, spe_clr_ok;
  logic          ram_wr_req = 0, ram_wr_cmd = 0, ram_wr_ok;
  logic [PW-1:0] ram_wr_idx = 0, cur_ptr = 0, end_ptr = 0;
  logic          cmd_done = 0, halt_req = 0, wrap_en = 0;
  logic          irq, access_err;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // Reference state.
  logic [15:0] m_en;     // enable bits kept at their register positions
  logic        m_fc, m_fa, m_ff, m_armed, m_xq;

  always #10 clk = ~clk;

  qspi_irq_ctl #(.PTR_W(PW)) i_qspi_irq_ctl (.*);

  function automatic logic f_coll();
    return xfer_active && ram_wr_req && ram_wr_cmd && (ram_wr_idx == cur_ptr);
  endfunction
  function automatic logic f_abort();
    return xfer_active && spe_clr_req && !m_en[12];
  endfunction
  function automatic logic f_fin();
    return cmd_done && ((cur_ptr == end_ptr) || halt_req) &&
           (m_armed || (xfer_active && !m_xq));
  endfunction
  function automatic logic [15:0] f_word();
    return (m_en & 16'hDD00) | {12'd0, m_fc, m_fa, 1'b0, m_ff};
  endfunction
  function automatic logic f_irq();
    return (m_fc && m_en[11]) || (m_fa && m_en[10]) || (m_ff && m_en[8]);
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  // Called in the low phase: check outputs, cross the edge, update the model.
  task automatic step(input string tag);
    logic c, a, f, ce, ae;
    #2;
    c = f_coll(); a = f_abort(); f = f_fin();
    ce = c && m_en[15]; ae = a && m_en[14];
    chk({tag, " R1 rdata"}, reg_rdata, f_word());
    chk({tag, " R12 irq"}, {15'd0, irq}, {15'd0, f_irq()});
    chk({tag, " R3 ram_wr_ok"}, {15'd0, ram_wr_ok}, {15'd0, ram_wr_req && !ce});
    chk({tag, " R5 spe_clr_ok"}, {15'd0, spe_clr_ok},
        {15'd0, spe_clr_req && !m_en[12] && !ae});
    chk({tag, " R5 access_err"}, {15'd0, access_err}, {15'd0, ce || ae});
    @(posedge clk); #1;
    m_fc = c | (m_fc & ~(reg_wr & reg_wdata[3]));
    m_fa = a | (m_fa & ~(reg_wr & reg_wdata[2]));
    m_ff = f | (m_ff & ~(reg_wr & reg_wdata[0]));
    if (xfer_active && !m_xq) m_armed = 1;
    if (f && (!wrap_en || halt_req)) m_armed = 0;
    m_xq = xfer_active;
    if (reg_wr) m_en = reg_wdata & 16'hDD00;
    @(negedge clk);
  endtask

  task automatic idle();
    reg_wr = 0; ram_wr_req = 0; spe_clr_req = 0; cmd_done = 0; halt_req = 0;
  endtask

  task automatic wreg(input logic [15:0] v, input string tag);
    reg_wr = 1; reg_wdata = v; step(tag); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_en = 0; m_fc = 0; m_fa = 0; m_ff = 0; m_armed = 0; m_xq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R13 reset rdata", reg_rdata, 16'h0000);
    chk("R13 reset irq", {15'd0, irq}, 16'h0000);
    step("R13");

    // R1: only the enable bits stick
    wreg(16'hFFFF, "R1 write");
    chk("R1 layout", reg_rdata, 16'hDD00);
    wreg(16'h0000, "R1 clear");

    // R2: collision, plus a non-matching index
    xfer_active = 1; cur_ptr = 4'd5; step("R9 arm");
    ram_wr_req = 1; ram_wr_cmd = 1; ram_wr_idx = 4'd6; step("R2 miss"); idle();
    chk("R2 no flag on other idx", {15'd0, reg_rdata[3]}, 16'h0000);
    ram_wr_req = 1; ram_wr_cmd = 1; ram_wr_idx = 4'd5; step("R2 hit"); idle();
    chk("R2 flag set", {15'd0, reg_rdata[3]}, 16'h0001);

    // R12/R10: enable and clears
    wreg(16'h0800, "R12 ie");
    chk("R12 irq on", {15'd0, irq}, 16'h0001);
    wreg(16'h0800, "R10 write0");
    chk("R10 zero keeps flag", {15'd0, reg_rdata[3]}, 16'h0001);
    wreg(16'h0808, "R10 w1c");
    chk("R10 flag cleared", {15'd0, reg_rdata[3]}, 16'h0000);
    chk("R12 irq off", {15'd0, irq}, 16'h0000);

    // R3: collision error blocks the write
    wreg(16'h8000, "R3 en");
    ram_wr_req = 1; ram_wr_cmd = 1; ram_wr_idx = 4'd5; #2;
    chk("R3 access_err", {15'd0, access_err}, 16'h0001);
    chk("R3 write blocked", {15'd0, ram_wr_ok}, 16'h0000);
    step("R3"); idle();

    // R4/R5 abort
    wreg(16'h0000, "R4 en");
    spe_clr_req = 1; step("R4"); idle();
    chk("R4 abort flag", {15'd0, reg_rdata[2]}, 16'h0001);
    wreg(16'h4004, "R5 en");
    spe_clr_req = 1; #2;
    chk("R5 clear blocked", {15'd0, spe_clr_ok}, 16'h0000);
    step("R5"); idle();
    chk("R5 flag still sets", {15'd0, reg_rdata[2]}, 16'h0001);

    // R6 lock-out
    wreg(16'h5004, "R6 en");
    spe_clr_req = 1; #2;
    chk("R6 no permission", {15'd0, spe_clr_ok}, 16'h0000);
    chk("R6 no error", {15'd0, access_err}, 16'h0000);
    step("R6"); idle();
    chk("R6 no abort flag", {15'd0, reg_rdata[2]}, 16'h0000);
    wreg(16'h0000, "R6 off");

    // R7: finish at end pointer only
    end_ptr = 4'd9; cur_ptr = 4'd3; cmd_done = 1; step("R7 miss"); idle();
    chk("R7 not at end", {15'd0, reg_rdata[0]}, 16'h0000);
    cur_ptr = 4'd9; cmd_done = 1; step("R7 hit"); idle();
    chk("R7 finished", {15'd0, reg_rdata[0]}, 16'h0001);
    wreg(16'h0001, "R7 clr");

    // R9: single-pass is disarmed now
    cmd_done = 1; step("R9 second"); idle();
    chk("R9 no reissue", {15'd0, reg_rdata[0]}, 16'h0000);
    xfer_active = 0; step("R9 stop");
    xfer_active = 1; wrap_en = 1; step("R9 rearm");
    cmd_done = 1; step("R9 wrap1"); idle();
    wreg(16'h0001, "R9 clr");
    cmd_done = 1; step("R9 wrap2"); idle();
    chk("R9 wrap reissue", {15'd0, reg_rdata[0]}, 16'h0001);

    // R11: set beats same-cycle clear
    cmd_done = 1; reg_wr = 1; reg_wdata = 16'h0001; step("R11"); idle();
    chk("R11 set wins", {15'd0, reg_rdata[0]}, 16'h0001);
    wreg(16'h0001, "R11 clr");

    // R8: halt at a non-end pointer
    cur_ptr = 4'd2; halt_req = 1; cmd_done = 1; step("R8"); idle();
    chk("R8 halt finish", {15'd0, reg_rdata[0]}, 16'h0001);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      reg_wr      = ($urandom % 10) == 0;
      reg_wdata   = 16'($urandom);
      if (($urandom % 20) == 0) xfer_active = ~xfer_active;
      if (($urandom % 30) == 0) wrap_en = ~wrap_en;
      ram_wr_req  = ($urandom % 3) == 0;
      ram_wr_cmd  = ($urandom % 2) == 0;
      ram_wr_idx  = PW'($urandom % 4);
      cur_ptr     = PW'($urandom % 4);
      end_ptr     = PW'($urandom % 4);
      cmd_done    = ($urandom % 3) == 0;
      halt_req    = ($urandom % 10) == 0;
      spe_clr_req = ($urandom % 7) == 0;
      step("rand");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule